// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block decides when an SDRAM must be refreshed and tracks whether the memory is sleeping in self-refresh. Software programs a small control register that turns periodic refresh on or off, selects one of eight refresh periods, and chooses whether leaving the processor's HALT state should also wake the memory. A down-counter paces periodic auto-refresh requests. A separate 3-bit command field lets software put the memory into self-refresh or bring it out again.

Every request to the downstream SDRAM command arbiter is a registered level that stays high until the arbiter returns a one-cycle acknowledge. A refresh that falls due while an earlier one is still waiting merges into it. Whenever self-refresh ends, whether by command or by HALT release, one auto-refresh is requested at once and the period counter restarts. Periodic refresh then continues.

Top module: `sdr_refresh_seq`

## Requirements
- R1: After a synchronous active-high reset, the control register reads 0x00, the command field reads 000, the self-refresh status is 0, and no request is raised.
- R2: Control register layout: bit 0 enables periodic refresh, bits 3:1 select the period, bit 4 enables wake on HALT release. Bits 7:5 read as 0 and writes to them are ignored.
- R3: With refresh enabled, the first refresh request appears N cycles after the write to the control register, and requests follow every N cycles. N is 47, 78, 156, 312, 468, 624, 936 or 1248 for select codes 0 to 7.
- R4: With bit 0 clear, no periodic refresh request is raised.
- R5: A request stays high until its acknowledge is sampled, and it is low in the cycle after that acknowledge.
- R6: A refresh that falls due while one is pending does not queue. One acknowledge clears the request, and the next request comes at the next multiple of N.
- R7: Writing command 101 while outside self-refresh raises the entry request. Its acknowledge sets the self-refresh status to 1.
- R8: No periodic refresh request is raised while the status is 1.
- R9: Writing command 110 while in self-refresh raises the exit request. Its acknowledge clears the status, raises a refresh request and returns the command field to 000, all on the same edge.
- R10: A HALT-release pulse in self-refresh raises the exit request only when bit 4 is 1. With bit 4 at 0, or outside self-refresh, the pulse has no effect.
- R11: After an exit, the next periodic refresh request comes N cycles after the exit acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| cmd_we | input | 1 | Command field write strobe |
| cmd_wdata | input | 3 | Command code written |
| cmd_rdata | output | 3 | Command field read value |
| halt_release | input | 1 | One-cycle pulse when the CPU leaves HALT |
| ref_req | output | 1 | Auto-refresh request to the arbiter |
| ref_ack | input | 1 | Auto-refresh acknowledge |
| sr_enter_req | output | 1 | Self-refresh entry request |
| sr_enter_ack | input | 1 | Self-refresh entry acknowledge |
| sr_exit_req | output | 1 | Self-refresh exit request |
| sr_exit_ack | input | 1 | Self-refresh exit acknowledge |
| sr_active | output | 1 | Memory is in self-refresh |

## Verification
A command write or HALT pulse shows up on its request output one edge later. An acknowledge clears its request on the edge where it is sampled, and an exit acknowledge changes the status, the refresh request and the command field on that same edge. A periodic request rises exactly N edges after the control write or the exit acknowledge that restarted the counter. The bench keeps a free-running edge counter and records the edge of each stimulus. It then checks outputs on the falling edge just before and just after each computed due edge, sweeping all eight period codes.

// File: rtl/sdr_refresh_pkg.sv
package sdr_refresh_pkg;
  localparam int SEL_W = 3;
  localparam int CMD_W = 3;
  localparam int CNT_W = 11;
  localparam int REG_W = 8;

  localparam logic [CMD_W-1:0] CMD_NOP      = 3'b000;
  localparam logic [CMD_W-1:0] CMD_SR_ENTER = 3'b101;
  localparam logic [CMD_W-1:0] CMD_SR_EXIT  = 3'b110;

  typedef struct packed {
    logic             wake_on_halt;
    logic [SEL_W-1:0] period_sel;
    logic             refresh_on;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic [CNT_W-1:0] period_cycles(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    period_cycles = 11'd47;
      3'd1:    period_cycles = 11'd78;
      3'd2:    period_cycles = 11'd156;
      3'd3:    period_cycles = 11'd312;
      3'd4:    period_cycles = 11'd468;
      3'd5:    period_cycles = 11'd624;
      3'd6:    period_cycles = 11'd936;
      default: period_cycles = 11'd1248;
    endcase
  endfunction
endpackage

// File: rtl/sdr_ref_ctrl_reg.sv
module sdr_ref_ctrl_reg
  import sdr_refresh_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output ctrl_t            ctrl,
  output logic [REG_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)     ctrl <= '0;
    else if (we) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
  end

  assign rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl};
endmodule

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer
  import sdr_refresh_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             hold,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  output logic             due
);
  logic [CNT_W-1:0] cnt;

  assign due = enable && !hold && !restart && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (restart || hold || !enable || due)
      cnt <= period - 1'b1;
    else
      cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/sdr_ref_srctl.sv
module sdr_ref_srctl
  import sdr_refresh_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             due,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic             halt_release,
  input  logic             wake_on_halt,
  input  logic             ref_ack,
  input  logic             sr_enter_ack,
  input  logic             sr_exit_ack,
  output logic             ref_req,
  output logic             sr_enter_req,
  output logic             sr_exit_req,
  output logic             sr_active,
  output logic [CMD_W-1:0] cmd_field,
  output logic             exit_done
);
  logic enter_start, exit_start;

  assign exit_done   = sr_exit_req && sr_exit_ack;
  assign enter_start = !sr_active && !sr_enter_req && cmd_we && (cmd_wdata == CMD_SR_ENTER);
  assign exit_start  = sr_active && !sr_exit_req &&
                       ((cmd_we && (cmd_wdata == CMD_SR_EXIT)) || (halt_release && wake_on_halt));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_field    <= CMD_NOP;
      sr_enter_req <= 1'b0;
      sr_exit_req  <= 1'b0;
      sr_active    <= 1'b0;
      ref_req      <= 1'b0;
    end else begin
      if (exit_done)   cmd_field <= CMD_NOP;
      else if (cmd_we) cmd_field <= cmd_wdata;

      if (enter_start)       sr_enter_req <= 1'b1;
      else if (sr_enter_ack) sr_enter_req <= 1'b0;

      if (exit_start)       sr_exit_req <= 1'b1;
      else if (sr_exit_ack) sr_exit_req <= 1'b0;

      if (sr_enter_req && sr_enter_ack) sr_active <= 1'b1;
      else if (exit_done)               sr_active <= 1'b0;

      if (due || exit_done) ref_req <= 1'b1;
      else if (ref_ack)     ref_req <= 1'b0;
    end
  end
endmodule

// File: rtl/sdr_refresh_seq.sv
module sdr_refresh_seq
  import sdr_refresh_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_wdata,
  output logic [CMD_W-1:0] cmd_rdata,
  input  logic             halt_release,
  output logic             ref_req,
  input  logic             ref_ack,
  output logic             sr_enter_req,
  input  logic             sr_enter_ack,
  output logic             sr_exit_req,
  input  logic             sr_exit_ack,
  output logic             sr_active
);
  ctrl_t            ctrl;
  ctrl_t            ctrl_next;
  logic             due, exit_done;
  logic [CNT_W-1:0] period;

  sdr_ref_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .ctrl(ctrl), .rdata(cfg_rdata)
  );

  assign ctrl_next = cfg_we ? ctrl_t'(cfg_wdata[CTRL_W-1:0]) : ctrl;
  assign period    = period_cycles(ctrl_next.period_sel);

  sdr_ref_timer u_timer (
    .clk(clk), .rst(rst), .enable(ctrl_next.refresh_on), .hold(sr_active),
    .restart(cfg_we || exit_done), .period(period), .due(due)
  );

  sdr_ref_srctl u_sr (
    .clk(clk), .rst(rst), .due(due), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .halt_release(halt_release), .wake_on_halt(ctrl.wake_on_halt),
    .ref_ack(ref_ack), .sr_enter_ack(sr_enter_ack), .sr_exit_ack(sr_exit_ack),
    .ref_req(ref_req), .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req),
    .sr_active(sr_active), .cmd_field(cmd_rdata), .exit_done(exit_done)
  );
endmodule

// File: rtl/sdr_refresh_seq_chk.sv
module sdr_refresh_seq_chk
  import sdr_refresh_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             cmd_we,
  input logic [CMD_W-1:0] cmd_wdata,
  input logic [CMD_W-1:0] cmd_rdata,
  input logic             halt_release,
  input logic             ref_req,
  input logic             ref_ack,
  input logic             sr_enter_req,
  input logic             sr_enter_ack,
  input logic             sr_exit_req,
  input logic             sr_exit_ack,
  input logic             sr_active
);
  a_r5_ref_held: assert property (@(posedge clk) disable iff (rst)
    ref_req && !ref_ack |=> ref_req);

  a_r8_no_refresh_in_sr: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_req) |-> !sr_active);

  a_r9_exit_effects: assert property (@(posedge clk) disable iff (rst)
    $fell(sr_active) |-> ref_req && (cmd_rdata == CMD_NOP));

  a_r9_exit_acked: assert property (@(posedge clk) disable iff (rst)
    $fell(sr_active) |-> $past(sr_exit_req && sr_exit_ack));

  a_r7_entry_acked: assert property (@(posedge clk) disable iff (rst)
    $rose(sr_active) |-> $past(sr_enter_req && sr_enter_ack));

  a_r10_no_wake: assert property (@(posedge clk) disable iff (rst)
    sr_active && !sr_exit_req && halt_release && !cfg_rdata[4] &&
    !(cmd_we && cmd_wdata == CMD_SR_EXIT) |=> !sr_exit_req);
endmodule

bind sdr_refresh_seq sdr_refresh_seq_chk chk_i (
  .clk(clk), .rst(rst), .cfg_rdata(cfg_rdata), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
  .cmd_rdata(cmd_rdata), .halt_release(halt_release), .ref_req(ref_req), .ref_ack(ref_ack),
  .sr_enter_req(sr_enter_req), .sr_enter_ack(sr_enter_ack), .sr_exit_req(sr_exit_req),
  .sr_exit_ack(sr_exit_ack), .sr_active(sr_active)
);

// File: tb/sdr_refresh_seq_tb.sv
module sdr_refresh_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       cmd_we = 1'b0;
  logic [2:0] cmd_wdata = '0;
  logic [2:0] cmd_rdata;
  logic       halt_release = 1'b0;
  logic       ref_req, ref_ack = 1'b0;
  logic       sr_enter_req, sr_enter_ack = 1'b0;
  logic       sr_exit_req, sr_exit_ack = 1'b0;
  logic       sr_active;

  int total = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdr_refresh_seq dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .halt_release(halt_release), .ref_req(ref_req), .ref_ack(ref_ack),
    .sr_enter_req(sr_enter_req), .sr_enter_ack(sr_enter_ack),
    .sr_exit_req(sr_exit_req), .sr_exit_ack(sr_exit_ack), .sr_active(sr_active)
  );

  function automatic int period_of(input int sel);
    case (sel)
      0: return 47;   1: return 78;   2: return 156;  3: return 312;
      4: return 468;  5: return 624;  6: return 936;  default: return 1248;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic write_cmd(input logic [2:0] v);
    cmd_we = 1'b1; cmd_wdata = v;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic pulse_ref_ack();
    ref_ack = 1'b1; @(negedge clk); ref_ack = 1'b0;
  endtask

  task automatic pulse_enter_ack();
    sr_enter_ack = 1'b1; @(negedge clk); sr_enter_ack = 1'b0;
  endtask

  task automatic pulse_exit_ack();
    sr_exit_ack = 1'b1; @(negedge clk); sr_exit_ack = 1'b0;
  endtask

  task automatic pulse_halt();
    halt_release = 1'b1; @(negedge clk); halt_release = 1'b0;
  endtask

  task automatic enter_sr();
    if (ref_req) pulse_ref_ack();
    write_cmd(3'b101);
    chk(sr_enter_req == 1'b1, "R7 entry request", sr_enter_req, 1);
    chk(sr_active == 1'b0, "R7 status before ack", sr_active, 0);
    pulse_enter_ack();
    chk(sr_active == 1'b1 && sr_enter_req == 1'b0, "R7 status after ack",
        {sr_active, sr_enter_req}, 2'b10);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int w, n, x;
    bit seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(cfg_rdata == 8'h00, "R1 control reg", cfg_rdata, 0);
    chk(cmd_rdata == 3'b000, "R1 command field", cmd_rdata, 0);
    chk({ref_req, sr_enter_req, sr_exit_req, sr_active} == 4'b0, "R1 outputs",
        {ref_req, sr_enter_req, sr_exit_req, sr_active}, 0);

    // R2 layout and reserved bits
    write_cfg(8'hFF);
    chk(cfg_rdata == 8'h1F, "R2 reserved bits read 0", cfg_rdata, 8'h1F);
    write_cfg(8'hE0);
    chk(cfg_rdata == 8'h00, "R2 reserved writes ignored", cfg_rdata, 0);
    write_cfg(8'h15);
    chk(cfg_rdata == 8'h15, "R2 field layout", cfg_rdata, 8'h15);

    // R3 / R5 sweep of every period code
    for (int s = 0; s < 8; s++) begin
      if (ref_req) pulse_ref_ack();
      write_cfg({4'b0000, 3'(s), 1'b1});
      w = cyc;
      n = period_of(s);
      wait_to(w + n - 1);
      chk(ref_req == 1'b0, $sformatf("R3 sel %0d early", s), ref_req, 0);
      wait_to(w + n);
      chk(ref_req == 1'b1, $sformatf("R3 sel %0d first due", s), ref_req, 1);
      pulse_ref_ack();
      chk(ref_req == 1'b0, $sformatf("R5 sel %0d cleared by ack", s), ref_req, 0);
      wait_to(w + 2*n - 1);
      chk(ref_req == 1'b0, $sformatf("R3 sel %0d second early", s), ref_req, 0);
      wait_to(w + 2*n);
      chk(ref_req == 1'b1, $sformatf("R3 sel %0d second due", s), ref_req, 1);
      pulse_ref_ack();
    end

    // R6 merge of an overdue refresh
    write_cfg(8'h01);
    w = cyc;
    wait_to(w + 47);
    chk(ref_req == 1'b1, "R6 first due", ref_req, 1);
    wait_to(w + 94);
    chk(ref_req == 1'b1, "R5 held while pending", ref_req, 1);
    pulse_ref_ack();
    chk(ref_req == 1'b0, "R6 one ack clears merged", ref_req, 0);
    wait_to(w + 140);
    chk(ref_req == 1'b0, "R6 no queued request", ref_req, 0);
    wait_to(w + 141);
    chk(ref_req == 1'b1, "R6 next multiple", ref_req, 1);
    pulse_ref_ack();

    // R4 disabled refresh
    write_cfg(8'h00);
    seen = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (ref_req) seen = 1'b1;
    end
    chk(seen == 1'b0, "R4 no refresh when disabled", seen, 0);

    // R10 HALT pulse outside self-refresh
    write_cfg(8'h11);
    pulse_halt();
    chk(sr_exit_req == 1'b0, "R10 halt outside self-refresh", sr_exit_req, 0);

    // R7 entry, R8 silence in self-refresh
    write_cfg(8'h01);
    enter_sr();
    chk(cmd_rdata == 3'b101, "R7 command field holds code", cmd_rdata, 3'b101);
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (ref_req) seen = 1'b1;
    end
    chk(seen == 1'b0, "R8 no refresh in self-refresh", seen, 0);

    // R10 no wake when disabled, wake when enabled
    pulse_halt();
    chk(sr_exit_req == 1'b0 && sr_active == 1'b1, "R10 halt ignored with bit 4 clear",
        {sr_exit_req, sr_active}, 2'b01);
    write_cfg(8'h11);
    pulse_halt();
    chk(sr_exit_req == 1'b1, "R10 halt wakes with bit 4 set", sr_exit_req, 1);
    pulse_exit_ack();
    x = cyc;
    chk(sr_active == 1'b0 && ref_req == 1'b1 && cmd_rdata == 3'b000,
        "R9 exit effects after wake", {sr_active, ref_req, cmd_rdata}, 5'b01000);
    pulse_ref_ack();
    wait_to(x + 46);
    chk(ref_req == 1'b0, "R11 before resume", ref_req, 0);
    wait_to(x + 47);
    chk(ref_req == 1'b1, "R11 periodic resumes", ref_req, 1);
    pulse_ref_ack();

    // R9 exit by command
    write_cfg(8'h03);
    enter_sr();
    write_cmd(3'b110);
    chk(sr_exit_req == 1'b1, "R9 exit request", sr_exit_req, 1);
    chk(sr_active == 1'b1, "R9 status held until ack", sr_active, 1);
    pulse_exit_ack();
    x = cyc;
    chk(sr_active == 1'b0 && ref_req == 1'b1 && cmd_rdata == 3'b000,
        "R9 exit effects after command", {sr_active, ref_req, cmd_rdata}, 5'b01000);
    pulse_ref_ack();
    wait_to(x + 77);
    chk(ref_req == 1'b0, "R11 sel 1 before resume", ref_req, 0);
    wait_to(x + 78);
    chk(ref_req == 1'b1, "R11 sel 1 resumes", ref_req, 1);
    pulse_ref_ack();

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule